// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

This block gathers interrupt requests from a set of external sources into a register of raised bits, one bit per internal line. Each external source is routed to an internal line through a routing table fixed by a parameter. Each line is either edge-type or level-type, also chosen by a parameter. An edge-type bit stays raised until software clears it. A level-type bit drops when its source goes low. Software can raise and clear bits directly, and it can read back the raw bits and the enable mask.

Every line belongs to one priority level. Line `l` sits at level `(l mod NUM_LEVELS) + 1`. A line is pending when its raised bit and its enable bit are both 1. On every cycle the controller looks for the highest level that is strictly above the level the core is running at and that holds a pending line. It reports that level as a registered number, together with a request to the core. When no level qualifies, it reports level 0 and keeps the request low.

Top module: `pic_prio_ctrl`

## Requirements
- R1: A rising edge on an external input whose table entry names a valid line sets that line's raised bit. The bit shows on a raw read (address 3, bit position = line number) after the next clock edge.
- R2: A falling edge on an external input routed to a level-type line clears that line's raised bit at the same clock edge.
- R3: The raised bit of an edge-type line (a line whose bit is 1 in `EDGE_MASK`) stays set after its input falls. It stays set until software clears it.
- R4: The pending set is the raised bits ANDed with the enable mask. The reported level is the highest level above `cur_level` that holds a pending line, and `irq_req` is 1 whenever that level is nonzero.
- R5: When no level above `cur_level` holds a pending line, `pend_level` is 0 and `irq_req` is 0. A `cur_level` at or above `NUM_LEVELS` masks every line.
- R6: Write data bits at or above `NUM_LINES` are ignored by every register, and such bits read as 0.
- R7: An external input whose table entry is at or above `NUM_LINES` is connected to no line, so it changes no raised bit.
- R8: `pend_level` and `irq_req` are registered. They follow a change of the raised bits, the enable mask or `cur_level` one clock edge later, which is two edges after an input change.
- R9: A clear write beats an edge that sets the same bit in the same cycle. Bits that are not written to 1 in the clear data are still set by their edges.
- R10: The register map is: address 0 is the enable mask (read/write); address 1 sets every bit written as 1; address 2 clears every bit written as 1; address 3 reads the raised bits. Reads of addresses 1 and 2 return 0.
- R11: After reset, the raised bits, the enable mask, `pend_level` and `irq_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | NUM_EXT | External interrupt sources, synchronous to clk |
| cur_level | input | LVL_W | Level at which the core is running |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| pend_level | output | LVL_W | Highest qualifying pending level, 0 if none |
| irq_req | output | 1 | Request to the core |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a rising edge on an edge-type line. It is equally hard to show that this clear touches only the bits it writes. Directed steps line up the input edge and the clear write on the same falling clock edge. They do this once with the clear aimed at that line and once with the clear aimed at a different bit, and then read the raw bits back. Random stimulus then mixes input toggles, set, clear and enable writes, and moves of `cur_level`, including values above the top level. The bench compares every cycle against a model of the raised bits and of the level scan.

// File: rtl/pic_prio_pkg.sv
package pic_prio_pkg;

   typedef enum logic [1:0] {
      REG_ENABLE = 2'd0,
      REG_SET    = 2'd1,
      REG_CLEAR  = 2'd2,
      REG_RAW    = 2'd3
   } reg_sel_e;

   // priority level a line belongs to (1 .. nlev)
   function automatic int line_level(input int line, input int nlev);
      return (line % nlev) + 1;
   endfunction

endpackage

// File: rtl/pic_ext_router.sv
module pic_ext_router #(
   parameter int NUM_EXT   = 8,
   parameter int NUM_LINES = 24,
   parameter int MAP_W     = 6,
   parameter logic [NUM_EXT*MAP_W-1:0] EXT_MAP = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EXT-1:0]   ext_irq,
   output logic [NUM_LINES-1:0] line_rise,
   output logic [NUM_LINES-1:0] line_fall
);

   logic [NUM_EXT-1:0] prev_q;
   logic [NUM_EXT-1:0] ext_rise;
   logic [NUM_EXT-1:0] ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= ext_irq;
   end

   assign ext_rise = ext_irq & ~prev_q;
   assign ext_fall = ~ext_irq & prev_q;

   // entries at or beyond NUM_LINES never match a line: R7
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [NUM_EXT-1:0] hit;
      for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
         assign hit[e] = (EXT_MAP[e*MAP_W +: MAP_W] == MAP_W'(l));
      end
      assign line_rise[l] = |(hit & ext_rise);
      assign line_fall[l] = |(hit & ext_fall);
   end

endmodule

// File: rtl/pic_line_bank.sv
module pic_line_bank #(
   parameter int NUM_LINES = 24,
   parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_rise,
   input  logic [NUM_LINES-1:0] line_fall,
   input  logic [NUM_LINES-1:0] sw_set,
   input  logic [NUM_LINES-1:0] sw_clr,
   output logic [NUM_LINES-1:0] set_q
);

   logic [NUM_LINES-1:0] set_d;

   always_comb begin
      set_d = set_q | line_rise | sw_set;
      set_d = set_d & ~(line_fall & ~EDGE_MASK);
      set_d = set_d & ~sw_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) set_q <= '0;
      else        set_q <= set_d;
   end

   AST_LEVEL_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_q & $past(line_fall & ~EDGE_MASK)) == '0); // R2
   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(set_q) & EDGE_MASK & ~$past(sw_clr)) & ~set_q) == '0); // R3
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_q & $past(sw_clr)) == '0); // R9

endmodule

// File: rtl/pic_level_resolver.sv
module pic_level_resolver #(
   parameter int NUM_LINES  = 24,
   parameter int NUM_LEVELS = 6,
   parameter int LVL_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pending,
   input  logic [LVL_W-1:0]     cur_level,
   output logic [LVL_W-1:0]     pend_level,
   output logic                 irq_req
);

   function automatic logic [NUM_LINES-1:0] level_mask(input int v);
      logic [NUM_LINES-1:0] m;
      for (int l = 0; l < NUM_LINES; l++)
         m[l] = (pic_prio_pkg::line_level(l, NUM_LEVELS) == v);
      return m;
   endfunction

   logic [NUM_LEVELS:1] lvl_hit;
   logic [LVL_W-1:0]    best;

   for (genvar v = 1; v <= NUM_LEVELS; v++) begin : g_lvl
      localparam logic [NUM_LINES-1:0] MASK = level_mask(v);
      assign lvl_hit[v] = |(pending & MASK);
   end

   // ascending scan: the last qualifying level is the highest one
   always_comb begin
      best = '0;
      for (int v = 1; v <= NUM_LEVELS; v++)
         if (lvl_hit[v] && (v > int'(cur_level))) best = LVL_W'(v);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_level <= '0;
         irq_req    <= 1'b0;
      end else begin
         pend_level <= best;
         irq_req    <= (best != '0);
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (pend_level == '0)); // R5
   AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pend_level) <= NUM_LEVELS); // R4

endmodule

// File: rtl/pic_prio_ctrl.sv
module pic_prio_ctrl #(
   parameter int NUM_LINES  = 24,
   parameter int NUM_LEVELS = 6,
   parameter int NUM_EXT    = 8,
   parameter int DATA_W     = 32,
   parameter int MAP_W      = 6,
   parameter logic [NUM_LINES-1:0] EDGE_MASK = 24'h0F0F0F,
   parameter logic [NUM_EXT*MAP_W-1:0] EXT_MAP =
      {6'd12, 6'd22, 6'd30, 6'd17, 6'd23, 6'd0, 6'd9, 6'd4},
   localparam int LVL_W = $clog2(NUM_LEVELS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_irq,
   input  logic [LVL_W-1:0]   cur_level,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [LVL_W-1:0]   pend_level,
   output logic               irq_req
);
   import pic_prio_pkg::*;

   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..32");
   end
   if (DATA_W < NUM_LINES) begin : g_bad_data
      $error("DATA_W must cover NUM_LINES");
   end
   if ((1 << MAP_W) <= NUM_LINES) begin : g_bad_map
      $error("MAP_W too narrow for NUM_LINES");
   end
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("NUM_LEVELS must be at least 1");
   end

   logic [NUM_LINES-1:0] line_rise, line_fall;
   logic [NUM_LINES-1:0] sw_set, sw_clr;
   logic [NUM_LINES-1:0] set_q, en_q;
   reg_sel_e             sel;

   assign sel    = reg_sel_e'(reg_addr);
   assign sw_set = (reg_wr && sel == REG_SET)   ? reg_wdata[NUM_LINES-1:0] : '0;
   assign sw_clr = (reg_wr && sel == REG_CLEAR) ? reg_wdata[NUM_LINES-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         en_q <= '0;
      else if (reg_wr && sel == REG_ENABLE) en_q <= reg_wdata[NUM_LINES-1:0];
   end

   always_comb begin
      case (sel)
         REG_ENABLE: reg_rdata = DATA_W'(en_q);
         REG_RAW:    reg_rdata = DATA_W'(set_q);
         default:    reg_rdata = '0;
      endcase
   end

   pic_ext_router #(
      .NUM_EXT(NUM_EXT), .NUM_LINES(NUM_LINES), .MAP_W(MAP_W), .EXT_MAP(EXT_MAP)
   ) u_router (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
      .line_rise(line_rise), .line_fall(line_fall)
   );

   pic_line_bank #(
      .NUM_LINES(NUM_LINES), .EDGE_MASK(EDGE_MASK)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .line_rise(line_rise), .line_fall(line_fall),
      .sw_set(sw_set), .sw_clr(sw_clr), .set_q(set_q)
   );

   pic_level_resolver #(
      .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
   ) u_resolve (
      .clk(clk), .rst_n(rst_n), .pending(set_q & en_q), .cur_level(cur_level),
      .pend_level(pend_level), .irq_req(irq_req)
   );

   AST_REQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_level > $past(cur_level))); // R4
   AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ($past(set_q & en_q) != '0)); // R4

endmodule

// File: tb/pic_prio_ctrl_test.sv
module pic_prio_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 24;
   localparam int NV = 6;
   localparam int NE = 8;
   localparam int MW = 6;
   localparam logic [NL-1:0] EDGE = 24'h0F0F0F;
   localparam logic [NE*MW-1:0] MAP =
      {6'd12, 6'd22, 6'd30, 6'd17, 6'd23, 6'd0, 6'd9, 6'd4};

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NE-1:0] ext_irq = '0;
   logic [2:0]    cur_level = '0;
   logic          reg_wr = 0;
   logic [1:0]    reg_addr = 2'd3;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [2:0]    pend_level;
   logic          irq_req;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [NL-1:0] m_set, m_en;
   logic [NE-1:0] m_prev;
   logic [2:0]    exp_lvl;
   logic          exp_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   pic_prio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .cur_level(cur_level),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pend_level(pend_level), .irq_req(irq_req)
   );

   function automatic logic [NL-1:0] f_next(logic [NL-1:0] s, logic [NE-1:0] ext,
         logic [NE-1:0] prev, logic wr, logic [1:0] a, logic [31:0] d);
      logic [NL-1:0] r = '0, f = '0, sv = '0, cv = '0;
      for (int e = 0; e < NE; e++) begin
         int t = int'(MAP[e*MW +: MW]);
         if (t < NL) begin
            if (ext[e] && !prev[e]) r[t] = 1'b1;
            if (!ext[e] && prev[e]) f[t] = 1'b1;
         end
      end
      if (wr && a == 2'd1) sv = d[NL-1:0];
      if (wr && a == 2'd2) cv = d[NL-1:0];
      return (s | r | sv) & ~(f & ~EDGE) & ~cv;
   endfunction

   function automatic logic [2:0] f_lvl(logic [NL-1:0] p, logic [2:0] cur);
      logic [2:0] best = '0;
      for (int v = 1; v <= NV; v++)
         for (int l = 0; l < NL; l++)
            if (p[l] && ((l % NV) + 1) == v && v > int'(cur)) best = 3'(v);
      return best;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_set <= '0; m_en <= '0; m_prev <= '0; exp_lvl <= '0; exp_req <= 0;
      end else begin
         exp_lvl <= f_lvl(m_set & m_en, cur_level);
         exp_req <= (f_lvl(m_set & m_en, cur_level) != 0);
         m_set   <= f_next(m_set, ext_irq, m_prev, reg_wr, reg_addr, reg_wdata);
         m_prev  <= ext_irq;
         if (reg_wr && reg_addr == 2'd0) m_en <= reg_wdata[NL-1:0];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock; leaves the bus idle on a raw read at the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0; reg_addr = 2'd3;
      #1;
   endtask

   task automatic cmp_model(input string tag);
      chk({tag, " raw"}, reg_rdata, 32'(m_set));
      chk({tag, " level"}, 32'(pend_level), 32'(exp_lvl));
      chk({tag, " req"}, 32'(irq_req), 32'(exp_req));
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R11 reset state
      chk("R11 raw", reg_rdata, 0);
      chk("R11 level", 32'(pend_level), 0);
      chk("R11 req", 32'(irq_req), 0);
      reg_addr = 2'd0; #1;
      chk("R11 enable", reg_rdata, 0);

      // R6/R10 enable write, upper bits dropped
      wr(2'd0, 32'hFFFF_FFFF);
      step();
      reg_addr = 2'd0; #1;
      chk("R6 enable readback", reg_rdata, 32'h00FF_FFFF);
      reg_addr = 2'd3; #1;

      // R7 source 5 routed nowhere
      ext_irq[5] = 1; step(); step();
      chk("R7 raw", reg_rdata, 0);
      chk("R7 req", 32'(irq_req), 0);
      ext_irq[5] = 0; step();

      // R1/R8 source 0 -> line 4 (level-type, level 5)
      ext_irq[0] = 1; step();
      chk("R1 raw", reg_rdata, 32'h10);
      chk("R8 level lags", 32'(pend_level), 0);
      step();
      chk("R4 level", 32'(pend_level), 5);
      chk("R4 req", 32'(irq_req), 1);

      // R2 level-type falls clear
      ext_irq[0] = 0; step();
      chk("R2 raw", reg_rdata, 0);

      // R3 source 2 -> line 0 (edge-type, level 1)
      ext_irq[2] = 1; step();
      ext_irq[2] = 0; step(); step();
      chk("R3 sticky raw", reg_rdata, 32'h1);
      chk("R3 level", 32'(pend_level), 1);
      wr(2'd2, 32'h1); step();
      chk("R3 sw clear", reg_rdata, 0);

      // R10 software set, R5 masking by current level
      wr(2'd1, 32'h1); step(); step();
      chk("R10 sw set", reg_rdata, 32'h1);
      chk("R4 level1", 32'(pend_level), 1);
      cur_level = 3'd1; step();
      chk("R5 level", 32'(pend_level), 0);
      chk("R5 req", 32'(irq_req), 0);
      reg_addr = 2'd1; #1;
      chk("R10 set reads 0", reg_rdata, 0);
      reg_addr = 2'd2; #1;
      chk("R10 clear reads 0", reg_rdata, 0);
      reg_addr = 2'd3; #1;

      // R6 set write above line count
      wr(2'd1, 32'hFF00_0000); step();
      chk("R6 raw", reg_rdata, 32'h1);
      cur_level = 3'd0;
      wr(2'd2, 32'h1); step();

      // R9 source 4 -> line 17 (edge-type): clear on same bit wins
      ext_irq[4] = 1; wr(2'd2, 32'h0002_0000); step();
      chk("R9 clear wins", reg_rdata, 0);
      ext_irq[4] = 0; step();
      ext_irq[4] = 1; wr(2'd2, 32'h0000_0001); step();
      chk("R9 other bit", reg_rdata, 32'h0002_0000);
      step();
      chk("R9 level", 32'(pend_level), 6);
      ext_irq[4] = 0; wr(2'd2, 32'hFFFF_FFFF); step();
      cmp_model("R1 sync");

      // random phase
      for (int i = 0; i < 1500; i++) begin
         ext_irq = NE'($urandom);
         if ($urandom_range(3) == 0) wr(2'($urandom_range(2)), $urandom);
         if ($urandom_range(7) == 0) cur_level = 3'($urandom_range(7));
         step();
         cmp_model("R4 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule